// File: doc/BRIEF.md
# Two-Queue Conversion Command Scheduler

This block sequences conversion command words for an analog-to-digital converter from two queues that share one command memory. Each queue is given by a first and a last command address and is started by its own trigger input. The block reads the word at the current queue position from the memory in the same cycle. It sends one conversion request at a time to the converter over a start/done handshake and reports each completed conversion as a result write tagged with the command address and the queue.

The high-priority queue always wins. A low-priority trigger that arrives while the high queue is running is held as pending. A high-priority trigger that arrives while the low queue is running aborts the low queue's conversion in flight and suspends the low queue. The low queue continues by itself once the high queue finishes or stops at a pause point. A mode input chooses whether the low queue then starts again from its first word or repeats the word that was cut off. A command word with its pause bit set closes a sub-queue: after that word the queue waits for its next trigger. Extra triggers that cannot be served are recorded in sticky overrun flags.

Top module: `qcs_sched`

## Requirements
- R1: When a queue is idle, its trigger starts it at its first address. The next conversion request for that queue carries `cmd_addr` equal to that first address, and the queue status becomes active (code 1).
- R2: A low-queue trigger while the high queue is active sets the low status to pending (code 3). No low-queue conversion starts while the low queue is pending or suspended.
- R3: When both triggers arrive in the same cycle with both queues idle, the high queue becomes active and the low queue becomes pending.
- R4: A high trigger while the low queue is active sets the low status to suspended (code 4). If a low conversion is in flight, `conv_abort` pulses for one cycle and that conversion produces no result write. A `conv_done` that arrives while no request is in flight is ignored.
- R5: When the high queue goes idle or paused, a pending or suspended low queue becomes active in the same clock edge. After a suspension it restarts at its first address when `lo_resume_at_abort` is 0. When that input is 1, it re-issues the aborted address.
- R6: Bit CW of a command word is its pause bit. The low CW bits are the channel. When a paused word's conversion is done, the queue goes to paused (code 2). Its next trigger continues at the following address.
- R7: When the conversion at a queue's last address is done, the queue goes idle (code 0) and `queue_done` bit 0 (high) or bit 1 (low) pulses for one cycle.
- R8: A trigger for a queue that is active, pending or suspended sets that queue's overrun flag (bit 0 high, bit 1 low). The flag stays set until a 1 is written on the matching `ovr_clr` bit. A set in the same cycle wins over the clear.
- R9: Only one conversion is in flight at a time. `conv_start` pulses for one cycle with `conv_chan` taken from the addressed word, and the high queue is served first. Each accepted `conv_done` gives one `res_we` pulse with the command address and the queue (0 high, 1 low).
- R10: After reset both statuses are idle, the flags are clear and no request, abort, write or done pulse is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_hi | input | 1 | High-queue trigger |
| trig_lo | input | 1 | Low-queue trigger |
| hi_first | input | AW | High queue first address |
| hi_last | input | AW | High queue last address |
| lo_first | input | AW | Low queue first address |
| lo_last | input | AW | Low queue last address |
| lo_resume_at_abort | input | 1 | 1: low queue repeats the aborted word, 0: restarts |
| ovr_clr | input | 2 | Write-one-to-clear for the overrun flags |
| cmd_addr | output | AW | Command memory read address |
| cmd_word | input | CW+1 | Command word at cmd_addr, {pause, channel} |
| conv_start | output | 1 | Conversion request pulse |
| conv_chan | output | CW | Channel of the requested conversion |
| conv_abort | output | 1 | Abort pulse for the conversion in flight |
| conv_done | input | 1 | Converter finished |
| res_we | output | 1 | Result write pulse |
| res_addr | output | AW | Command address of the result |
| res_queue | output | 1 | Queue of the result |
| hi_status | output | 3 | High queue status code |
| lo_status | output | 3 | Low queue status code |
| ovr_flag | output | 2 | Sticky overrun flags |
| queue_done | output | 2 | Completion pulses |

## Verification
The hardest case to reach is a high trigger that lands while a low conversion is in flight, followed by a late done from the converter. Both resume modes must be covered, and a second low trigger has to arrive while the low queue is suspended. Directed sequences build this case on purpose. The random phase triggers the high queue rarely, so the low queue is usually running when a high trigger comes. Its converter model uses random latency and sends a stale done right after an abort about half the time. A cycle model in the bench checks every output in every cycle.

// File: rtl/qcs_pkg.sv
package qcs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ACTIVE    = 3'd1,
        ST_PAUSED    = 3'd2,
        ST_PENDING   = 3'd3,
        ST_SUSPENDED = 3'd4
    } qstat_e;
endpackage

// File: rtl/qcs_sticky.sv
module qcs_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = set_i | (flag_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/qcs_issue_sel.sv
module qcs_issue_sel
    import qcs_pkg::*;
#(
    parameter int AW = 6
) (
    input  qstat_e          st_hi,
    input  qstat_e          st_lo,
    input  logic [AW-1:0]   ptr_hi,
    input  logic [AW-1:0]   ptr_lo,
    input  logic            busy,
    input  logic            hold_lo,
    output logic            issue,
    output logic            issue_lo,
    output logic [AW-1:0]   addr
);
    logic hi_run, lo_run;

    always_comb begin
        hi_run   = (st_hi == ST_ACTIVE);
        lo_run   = (st_lo == ST_ACTIVE) && !hold_lo;
        issue    = !busy && (hi_run || lo_run);
        issue_lo = !hi_run;
        addr     = hi_run ? ptr_hi : ptr_lo;
    end
endmodule

// File: rtl/qcs_sched.sv
module qcs_sched
    import qcs_pkg::*;
#(
    parameter int AW = 6,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_hi,
    input  logic          trig_lo,
    input  logic [AW-1:0] hi_first,
    input  logic [AW-1:0] hi_last,
    input  logic [AW-1:0] lo_first,
    input  logic [AW-1:0] lo_last,
    input  logic          lo_resume_at_abort,
    input  logic [1:0]    ovr_clr,
    output logic [AW-1:0] cmd_addr,
    input  logic [CW:0]   cmd_word,
    output logic          conv_start,
    output logic [CW-1:0] conv_chan,
    output logic          conv_abort,
    input  logic          conv_done,
    output logic          res_we,
    output logic [AW-1:0] res_addr,
    output logic          res_queue,
    output logic [2:0]    hi_status,
    output logic [2:0]    lo_status,
    output logic [1:0]    ovr_flag,
    output logic [1:0]    queue_done
);
    localparam int PAUSE_BIT = CW;

    typedef struct packed {
        qstat_e        st_hi;
        qstat_e        st_lo;
        logic [AW-1:0] ptr_hi;
        logic [AW-1:0] ptr_lo;
        logic [AW-1:0] cur_addr;
        logic          busy;
        logic          own_lo;
        logic          cur_pause;
        logic [1:0]    comp;
    } state_t;

    state_t        s_d, s_q;
    logic          issue, issue_lo, abort_lo;
    logic [AW-1:0] sel_addr;
    logic [1:0]    ovr_set;

    qcs_issue_sel #(.AW(AW)) i_sel (
        .st_hi   (s_q.st_hi),
        .st_lo   (s_q.st_lo),
        .ptr_hi  (s_q.ptr_hi),
        .ptr_lo  (s_q.ptr_lo),
        .busy    (s_q.busy),
        .hold_lo (trig_hi),
        .issue   (issue),
        .issue_lo(issue_lo),
        .addr    (sel_addr)
    );

    for (genvar g = 0; g < 2; g++) begin : g_ovr
        qcs_sticky i_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (ovr_set[g]),
            .clr_i (ovr_clr[g]),
            .flag_o(ovr_flag[g])
        );
    end

    always_comb begin
        s_d        = s_q;
        s_d.comp   = 2'b00;
        ovr_set    = 2'b00;
        res_we     = 1'b0;
        conv_abort = 1'b0;

        // new request to the converter
        if (issue) begin
            s_d.busy      = 1'b1;
            s_d.own_lo    = issue_lo;
            s_d.cur_addr  = sel_addr;
            s_d.cur_pause = cmd_word[PAUSE_BIT];
        end

        abort_lo = trig_hi && (s_q.st_hi != ST_ACTIVE) && (s_q.st_lo == ST_ACTIVE);

        // converter finished (ignored for a low request being aborted)
        if (s_q.busy && conv_done && !(abort_lo && s_q.own_lo)) begin
            res_we   = 1'b1;
            s_d.busy = 1'b0;
            if (!s_q.own_lo) begin
                if (s_q.cur_addr == hi_last) begin
                    s_d.st_hi   = ST_IDLE;
                    s_d.comp[0] = 1'b1;
                end else begin
                    s_d.ptr_hi = s_q.cur_addr + 1'b1;
                    if (s_q.cur_pause) s_d.st_hi = ST_PAUSED;
                end
            end else begin
                if (s_q.cur_addr == lo_last) begin
                    s_d.st_lo   = ST_IDLE;
                    s_d.comp[1] = 1'b1;
                end else begin
                    s_d.ptr_lo = s_q.cur_addr + 1'b1;
                    if (s_q.cur_pause) s_d.st_lo = ST_PAUSED;
                end
            end
        end

        // high trigger
        if (trig_hi) begin
            case (s_d.st_hi)
                ST_IDLE: begin
                    s_d.ptr_hi = hi_first;
                    s_d.st_hi  = ST_ACTIVE;
                end
                ST_PAUSED: s_d.st_hi = ST_ACTIVE;
                default:   ovr_set[0] = 1'b1;
            endcase
        end

        // preemption of the low queue
        if (abort_lo) begin
            s_d.st_lo = ST_SUSPENDED;
            if (s_q.busy) begin
                conv_abort = 1'b1;
                s_d.busy   = 1'b0;
            end
            if (!lo_resume_at_abort) s_d.ptr_lo = lo_first;
        end

        // low trigger
        if (trig_lo) begin
            case (s_d.st_lo)
                ST_IDLE: begin
                    s_d.ptr_lo = lo_first;
                    s_d.st_lo  = (s_d.st_hi == ST_ACTIVE) ? ST_PENDING : ST_ACTIVE;
                end
                ST_PAUSED: s_d.st_lo = (s_d.st_hi == ST_ACTIVE) ? ST_PENDING : ST_ACTIVE;
                default:   ovr_set[1] = 1'b1;
            endcase
        end

        // low queue continues once the high queue steps aside
        if ((s_d.st_hi != ST_ACTIVE) &&
            ((s_d.st_lo == ST_PENDING) || (s_d.st_lo == ST_SUSPENDED))) begin
            s_d.st_lo = ST_ACTIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st_hi: ST_IDLE, st_lo: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_addr   = sel_addr;
    assign conv_start = issue;
    assign conv_chan  = cmd_word[CW-1:0];
    assign res_addr   = s_q.cur_addr;
    assign res_queue  = s_q.own_lo;
    assign hi_status  = s_q.st_hi;
    assign lo_status  = s_q.st_lo;
    assign queue_done = s_q.comp;
endmodule

// File: rtl/qcs_checks.sv
module qcs_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_hi,
    input logic       conv_start,
    input logic       conv_abort,
    input logic       res_we,
    input logic [2:0] hi_status,
    input logic [2:0] lo_status,
    input logic [1:0] ovr_flag,
    input logic [1:0] ovr_clr
);
    assert_one_inflight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_lo_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_status == 3'd3 || lo_status == 3'd4) |-> hi_status == 3'd1);

    assert_abort_suspends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |=> lo_status == 3'd4);

    assert_abort_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> !res_we);

    assert_hi_trig_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hi && hi_status != 3'd1) |=> hi_status == 3'd1);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ovr_flag & $past(ovr_flag & ~ovr_clr)) == $past(ovr_flag & ~ovr_clr)));
endmodule

bind qcs_sched qcs_checks i_qcs_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_hi   (trig_hi),
    .conv_start(conv_start),
    .conv_abort(conv_abort),
    .res_we    (res_we),
    .hi_status (hi_status),
    .lo_status (lo_status),
    .ovr_flag  (ovr_flag),
    .ovr_clr   (ovr_clr)
);

// File: tb/test_qcs_sched.sv
module test_qcs_sched;
    localparam int AW = 6;
    localparam int CW = 5;
    localparam int NCYC = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_hi = 0, trig_lo = 0, lo_resume_at_abort = 0, conv_done = 0;
    logic [AW-1:0] hi_first = 0, hi_last = 0, lo_first = 0, lo_last = 0;
    logic [1:0]    ovr_clr = 0;
    logic [AW-1:0] cmd_addr, res_addr;
    logic [CW:0]   cmd_word;
    logic          conv_start, conv_abort, res_we, res_queue;
    logic [CW-1:0] conv_chan;
    logic [2:0]    hi_status, lo_status;
    logic [1:0]    ovr_flag, queue_done;

    logic [CW:0] mem [64];
    assign cmd_word = mem[cmd_addr];

    qcs_sched #(.AW(AW), .CW(CW)) i_qcs_sched (.*);

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    bit finished = 0;

    // bench reference state
    logic [2:0]    m_st [2];
    logic [AW-1:0] m_ptr [2];
    logic [AW-1:0] m_cur;
    logic          m_busy, m_own, m_pause;
    logic [1:0]    m_comp, m_ovr;
    // next values
    logic [2:0]    x_st [2];
    logic [AW-1:0] x_ptr [2];
    logic [AW-1:0] x_cur;
    logic          x_busy, x_own, x_pause;
    logic [1:0]    x_comp, x_ovr;
    // converter model
    int  cv_cnt = 0;
    bit  cv_on = 0, cv_stale = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] lim(input logic [AW-1:0] q);
        return q ? lo_last : hi_last;
    endfunction

    task automatic model_eval_and_check();
        logic       e_issue, e_lo, e_abort, e_we, e_hold;
        logic [AW-1:0] e_addr;
        logic [1:0] setf;
        int q;
        e_hold  = trig_hi;
        e_issue = !m_busy && (m_st[0] == 3'd1 || (m_st[1] == 3'd1 && !e_hold));
        e_lo    = (m_st[0] != 3'd1);
        e_addr  = e_lo ? m_ptr[1] : m_ptr[0];
        x_st = m_st; x_ptr = m_ptr; x_cur = m_cur; x_busy = m_busy; x_own = m_own;
        x_pause = m_pause; x_comp = 2'b00; setf = 2'b00; e_we = 0;
        if (e_issue) begin
            x_busy = 1; x_own = e_lo; x_cur = e_addr; x_pause = mem[e_addr][CW];
        end
        e_abort = 0;
        if (trig_hi && m_st[0] != 3'd1 && m_st[1] == 3'd1) e_abort = 1;
        if (m_busy && conv_done && !(e_abort && m_own)) begin
            e_we = 1; x_busy = 0; q = m_own ? 1 : 0;
            if (m_cur == (q == 1 ? lo_last : hi_last)) begin
                x_st[q] = 3'd0; x_comp[q] = 1;
            end else begin
                x_ptr[q] = m_cur + 1'b1;
                if (m_pause) x_st[q] = 3'd2;
            end
        end
        if (trig_hi) begin
            if (x_st[0] == 3'd0) begin x_ptr[0] = hi_first; x_st[0] = 3'd1; end
            else if (x_st[0] == 3'd2) x_st[0] = 3'd1;
            else setf[0] = 1;
        end
        if (e_abort) begin
            x_st[1] = 3'd4;
            if (m_busy) x_busy = 0;
            if (!lo_resume_at_abort) x_ptr[1] = lo_first;
        end
        if (trig_lo) begin
            if (x_st[1] == 3'd0 || x_st[1] == 3'd2) begin
                if (x_st[1] == 3'd0) x_ptr[1] = lo_first;
                x_st[1] = (x_st[0] == 3'd1) ? 3'd3 : 3'd1;
            end else setf[1] = 1;
        end
        if (x_st[0] != 3'd1 && (x_st[1] == 3'd3 || x_st[1] == 3'd4)) x_st[1] = 3'd1;
        x_ovr = setf | (m_ovr & ~ovr_clr);

        chk("R9", "conv_start", int'(conv_start), int'(e_issue));
        if (e_issue) begin
            chk("R1 R5 R6", "cmd_addr", int'(cmd_addr), int'(e_addr));
            chk("R9", "conv_chan", int'(conv_chan), int'(mem[e_addr][CW-1:0]));
        end
        chk("R4", "conv_abort", int'(conv_abort), int'(e_abort && m_busy));
        chk("R9", "res_we", int'(res_we), int'(e_we));
        if (e_we) begin
            chk("R9", "res_addr", int'(res_addr), int'(m_cur));
            chk("R9", "res_queue", int'(res_queue), int'(m_own));
        end
        chk("R1 R3 R6", "hi_status", int'(hi_status), int'(m_st[0]));
        chk("R2 R3 R4 R5", "lo_status", int'(lo_status), int'(m_st[1]));
        chk("R8", "ovr_flag", int'(ovr_flag), int'(m_ovr));
        chk("R7", "queue_done", int'(queue_done), int'(m_comp));
    endtask

    task automatic cyc(input logic th, input logic tl, input logic [1:0] clr);
        trig_hi = th; trig_lo = tl; ovr_clr = clr;
        conv_done = cv_stale || (cv_on && cv_cnt == 0);
        #1;
        model_eval_and_check();
        cv_stale = 0;
        if (conv_abort) begin
            cv_on = 0; cv_stale = ($urandom % 2) == 1;
        end else if (cv_on && cv_cnt == 0) cv_on = 0;
        if (conv_start) begin cv_on = 1; cv_cnt = $urandom % 4; end
        else if (cv_on && cv_cnt > 0) cv_cnt--;
        @(posedge clk);
        m_st = x_st; m_ptr = x_ptr; m_cur = x_cur; m_busy = x_busy; m_own = x_own;
        m_pause = x_pause; m_comp = x_comp; m_ovr = x_ovr;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 2'b00);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) mem[i] = {1'b0, 5'(i)};
        mem[2][CW] = 1'b1;
        m_st[0] = 0; m_st[1] = 0; m_ptr[0] = 0; m_ptr[1] = 0; m_cur = 0;
        m_busy = 0; m_own = 0; m_pause = 0; m_comp = 0; m_ovr = 0;
        hi_first = 6'd0; hi_last = 6'd4; lo_first = 6'd32; lo_last = 6'd37;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "reset hi_status", int'(hi_status), 0);
        chk("R10", "reset lo_status", int'(lo_status), 0);
        chk("R10", "reset ovr_flag", int'(ovr_flag), 0);
        chk("R10", "reset conv_start", int'(conv_start), 0);
        chk("R10", "reset queue_done", int'(queue_done), 0);
        rst_n = 1;
        @(negedge clk);
        // R1 R7: low queue alone to its end
        cyc(0, 1, 2'b00); idle(40);
        // R3: simultaneous triggers, then R6 pause at word 2 and continue
        cyc(1, 1, 2'b00); idle(20); cyc(1, 0, 2'b00); idle(40);
        // R4 R5 mode 0: preempt low queue mid conversion
        lo_resume_at_abort = 0;
        cyc(0, 1, 2'b00); idle(4); cyc(1, 0, 2'b00);
        cyc(0, 1, 2'b00); idle(30); cyc(1, 0, 2'b00); idle(40);
        // R5 mode 1, then R8 overrun clear and set-wins
        lo_resume_at_abort = 1;
        cyc(0, 1, 2'b00); idle(6); cyc(1, 0, 2'b00); idle(30); cyc(1, 0, 2'b00); idle(40);
        cyc(0, 1, 2'b00); cyc(0, 1, 2'b10); cyc(0, 1, 2'b10); cyc(0, 0, 2'b10); idle(40);
        // random phase
        for (int i = 0; i < 64; i++) mem[i] = {($urandom % 4) == 0, 5'($urandom)};
        for (int n = 0; n < NCYC; n++) begin
            if (n % 500 == 0) begin
                hi_first = 6'($urandom % 8);  hi_last = hi_first + 6'($urandom % 6);
                lo_first = 6'(32 + $urandom % 8); lo_last = lo_first + 6'($urandom % 10);
                lo_resume_at_abort = $urandom % 2;
                idle(60);
            end
            cyc(($urandom % 25) == 0, ($urandom % 10) == 0,
                (($urandom % 12) == 0) ? 2'($urandom) : 2'b00);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule